// File: doc/BRIEF.md
# Seven-slot LVDS pixel serializer

This block turns one parallel RGB pixel, with its data-enable and the two sync flags, into seven serial bit-times on each of up to five data lanes, and produces a matching clock lane. It runs on a single fast bit clock. A pixel strobe that is high for one cycle in every seven marks the pixel boundary. On the strobe edge, the block captures the pixel and the mode inputs, builds the whole seven-slot word for every lane, and loads it into per-lane shift registers. Slot 0 leaves first. The next strobe reloads the shift registers exactly when the last slot has been shown, so consecutive pixels follow each other with no gap.

A run-time depth select chooses 18-bit colour on three lanes, 24-bit colour on four lanes or 30-bit colour on five lanes. For 24-bit and 30-bit colour, an order select chooses where the colour bits go. In the standard order, the low six bits of each channel sit on lanes 0 to 2 and the upper bits on the extra lanes. In the alternate order, the six most significant bits sit on lanes 0 to 2 and the low bits move to the extra lanes. Colour inputs are LSB-aligned: a depth of 6 or 8 bits per channel uses the low 6 or 8 bits of each 10-bit input and ignores the rest. A downstream driver stage takes the lane bits; analog drivers, PLLs and deskew are outside this block.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: The cycle after a clock edge with `pix_stb` high shows slot 0 of the captured pixel on every lane. Slots 1 to 6 follow on the next six cycles, one per cycle. A strobe every seventh cycle gives back-to-back pixels with no idle slot.
- R2: From the cycle after a strobe, `clk_lane_out` shows 1,1,0,0,0,1,1 across slots 0 to 6.
- R3: Lane 2 carries DE in slot 0, VSYNC in slot 1 and HSYNC in slot 2, in every mode.
- R4: With `depth_sel` 2'b00, or the reserved 2'b11, the mode is 18-bit. Lane 0 slots 0..6 carry g0,r5,r4,r3,r2,r1,r0. Lane 1 carries b1,b0,g5,g4,g3,g2,g1. Lane 2 slots 3..6 carry b5,b4,b3,b2. `jeida_sel` has no effect in this mode.
- R5: With `depth_sel` 2'b01 and `jeida_sel` 0, lanes 0 to 2 use the R4 layout on colour bits 0 to 5. Lane 3 slots 1..6 carry b7,b6,g7,g6,r7,r6.
- R6: With `depth_sel` 2'b01 and `jeida_sel` 1, lanes 0 to 2 use the R4 layout with colour bit k+2 in place of bit k. Lane 3 slots 1..6 carry b1,b0,g1,g0,r1,r0.
- R7: With `depth_sel` 2'b10 and `jeida_sel` 0, lanes 0 to 3 follow R5. Lane 4 slots 1..6 carry b9,b8,g9,g8,r9,r8.
- R8: With `depth_sel` 2'b10 and `jeida_sel` 1, lanes 0 to 2 use the R4 layout with bit k+4 in place of bit k. Lane 3 slots 1..6 carry b3,b2,g3,g2,r3,r2. Lane 4 slots 1..6 carry b1,b0,g1,g0,r1,r0.
- R9: Slot 0 of lane 3 and of lane 4 is low whenever that lane is active.
- R10: Lanes not used by the captured mode are held low: lane 3 in 18-bit mode, and lane 4 in 18-bit and 24-bit modes.
- R11: Mode and pixel inputs are sampled only on the strobe edge. Changes between strobes do not alter the pixel being shifted out.
- R12: After reset, all outputs are low. When no strobe follows a pixel, every lane and the clock lane are low from the eighth cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_stb | input | 1 | Pixel boundary strobe, one cycle wide |
| depth_sel | input | 2 | Colour depth: 00 18-bit, 01 24-bit, 10 30-bit, 11 18-bit |
| jeida_sel | input | 1 | 1 selects MSB-first lane placement for 24/30-bit |
| r_in | input | 10 | Red channel, LSB-aligned |
| g_in | input | 10 | Green channel, LSB-aligned |
| b_in | input | 10 | Blue channel, LSB-aligned |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| lane_out | output | 5 | Serial data lanes, bit n is lane n |
| clk_lane_out | output | 1 | Serial clock lane |

## Verification
Each lane register is reloaded at every pixel boundary, so a wrong mapping bit or a wrong latched mode is visible at the lane outputs within the seven slots of that same pixel. It does not carry over to the next pixel. A shifter that is off by one slot, or a clock-lane phase error, moves every bit of the word and breaks the slot-by-slot comparison at the first pixel. Corrupt mode latching shows up only when the select inputs change mid-pixel, so the bench inverts every input right after each strobe.

// File: rtl/lvds_ser_pkg.sv
// Shared constants, types and helpers for the seven-slot LVDS serializer.
// Assumes fixed seven slots per pixel and 10-bit colour channels.
package lvds_ser_pkg;

    localparam int SLOTS   = 7;
    localparam int LANES   = 5;
    localparam int COLOR_W = 10;
    localparam int BASE_W  = 6;
    localparam int EXT_W   = 2;

    // Colour depth codes as seen on depth_sel.
    typedef enum logic [1:0] {
        DEPTH_18  = 2'b00,
        DEPTH_24  = 2'b01,
        DEPTH_30  = 2'b10,
        DEPTH_RSV = 2'b11
    } depth_e;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic               de;
        logic               hs;
        logic               vs;
    } pixel_t;

    typedef logic [SLOTS-1:0] slot_word_t;

    // Clock lane pattern, bit n is slot n: 1,1,0,0,0,1,1.
    localparam slot_word_t CLK_PATTERN = 7'b1100011;

    // Word for an extra lane: slot 0 low, then b[1],b[0],g[1],g[0],r[1],r[0].
    function automatic slot_word_t ext_word(input logic [EXT_W-1:0] er,
                                            input logic [EXT_W-1:0] eg,
                                            input logic [EXT_W-1:0] eb);
        return {er[0], er[1], eg[0], eg[1], eb[0], eb[1], 1'b0};
    endfunction

endpackage

// File: rtl/lvds_slot_mapper.sv
// Builds the seven-slot word for every lane from one pixel and one mode.
// Purely combinational. Assumes LSB-aligned colour inputs. Lanes unused
// by the selected depth produce an all-zero word.
module lvds_slot_mapper
    import lvds_ser_pkg::*;
(
    input  pixel_t                        px,
    input  depth_e                        depth,
    input  logic                          msb_first,
    output logic [LANES-1:0][SLOTS-1:0]   words
);

    logic [BASE_W-1:0] br, bg, bb;
    logic [EXT_W-1:0]  e1r, e1g, e1b, e2r, e2g, e2b;
    logic              use_l3, use_l4;

    // Pick the six base bits and the two extra-lane bit pairs per channel.
    always_comb begin
        br = px.r[BASE_W-1:0];
        bg = px.g[BASE_W-1:0];
        bb = px.b[BASE_W-1:0];
        e1r = '0; e1g = '0; e1b = '0;
        e2r = '0; e2g = '0; e2b = '0;
        use_l3 = 1'b0;
        use_l4 = 1'b0;
        case (depth)
            DEPTH_30: begin
                use_l3 = 1'b1;
                use_l4 = 1'b1;
                if (msb_first) begin
                    br = px.r[9:4]; bg = px.g[9:4]; bb = px.b[9:4];
                    e1r = px.r[3:2]; e1g = px.g[3:2]; e1b = px.b[3:2];
                    e2r = px.r[1:0]; e2g = px.g[1:0]; e2b = px.b[1:0];
                end else begin
                    e1r = px.r[7:6]; e1g = px.g[7:6]; e1b = px.b[7:6];
                    e2r = px.r[9:8]; e2g = px.g[9:8]; e2b = px.b[9:8];
                end
            end
            DEPTH_24: begin
                use_l3 = 1'b1;
                if (msb_first) begin
                    br = px.r[7:2]; bg = px.g[7:2]; bb = px.b[7:2];
                    e1r = px.r[1:0]; e1g = px.g[1:0]; e1b = px.b[1:0];
                end else begin
                    e1r = px.r[7:6]; e1g = px.g[7:6]; e1b = px.b[7:6];
                end
            end
            default: ;
        endcase
    end

    // Place the bits into slot order, slot 0 in bit 0.
    always_comb begin
        words[0] = {br[0], br[1], br[2], br[3], br[4], br[5], bg[0]};
        words[1] = {bg[1], bg[2], bg[3], bg[4], bg[5], bb[0], bb[1]};
        words[2] = {bb[2], bb[3], bb[4], bb[5], px.hs, px.vs, px.de};
        words[3] = use_l3 ? ext_word(e1r, e1g, e1b) : '0;
        words[4] = use_l4 ? ext_word(e2r, e2g, e2b) : '0;
    end

endmodule

// File: rtl/lvds_lane_shifter.sv
// One lane's shift register: loads a full word on load, otherwise shifts
// toward bit 0 and fills with zero. Bit 0 is the lane output.
module lvds_lane_shifter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic             dout
);

    logic [WIDTH-1:0] sr;

    // Load a new word at the pixel boundary, otherwise advance one slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= din;
        else
            sr <= {1'b0, sr[WIDTH-1:1]};
    end

    assign dout = sr[0];

endmodule

// File: rtl/lvds_pixel_serializer.sv
// Top of the seven-slot serializer. Maps the pixel on the strobe edge and
// loads every lane plus the clock lane at once. Assumes pix_stb is one
// cycle wide; a strobe every seventh cycle gives gapless output.
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_stb,
    input  logic [1:0]         depth_sel,
    input  logic               jeida_sel,
    input  logic [COLOR_W-1:0] r_in,
    input  logic [COLOR_W-1:0] g_in,
    input  logic [COLOR_W-1:0] b_in,
    input  logic               de_in,
    input  logic               hs_in,
    input  logic               vs_in,
    output logic [LANES-1:0]   lane_out,
    output logic               clk_lane_out
);

    pixel_t                      px;
    logic [LANES-1:0][SLOTS-1:0] words;
    logic [1:0]                  depth_q;
    logic                        jeida_q;

    assign px = '{r: r_in, g: g_in, b: b_in, de: de_in, hs: hs_in, vs: vs_in};

    lvds_slot_mapper u_map (
        .px        (px),
        .depth     (depth_e'(depth_sel)),
        .msb_first (jeida_sel),
        .words     (words)
    );

    // Hold the mode of the pixel currently on the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= DEPTH_18;
            jeida_q <= 1'b0;
        end else if (pix_stb) begin
            depth_q <= depth_sel;
            jeida_q <= jeida_sel;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lvds_lane_shifter #(.WIDTH(SLOTS)) u_sh (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (pix_stb),
            .din   (words[l]),
            .dout  (lane_out[l])
        );
    end

    lvds_lane_shifter #(.WIDTH(SLOTS)) u_clk_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pix_stb),
        .din   (CLK_PATTERN),
        .dout  (clk_lane_out)
    );

endmodule

// File: rtl/lvds_ser_checker.sv
// Protocol checks for the serializer, bound to the top module.
// Tracks the slot index with its own counter.
module lvds_ser_checker
    import lvds_ser_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_stb,
    input logic             de_in,
    input logic             hs_in,
    input logic             vs_in,
    input logic [1:0]       depth_q,
    input logic [LANES-1:0] lane_out,
    input logic             clk_lane_out
);

    logic [2:0] slot;
    logic       live;

    // Slot index of the word now on the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            live <= 1'b0;
        end else if (pix_stb) begin
            slot <= '0;
            live <= 1'b1;
        end else if (live) begin
            if (slot == 3'(SLOTS - 1)) live <= 1'b0;
            else                       slot <= slot + 3'd1;
        end
    end

    p_clk_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> clk_lane_out == CLK_PATTERN[slot]);

    p_de_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> lane_out[2] == $past(de_in));

    p_vs_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_stb, 2) && !$past(pix_stb) && live && slot == 3'd1)
            |-> lane_out[2] == $past(vs_in, 2));

    p_ext_slot0_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> lane_out[4:3] == 2'b00);

    p_lane4_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q != 2'b10 |-> !lane_out[4]);

    p_lane3_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q == 2'b00 || depth_q == 2'b11) |-> !lane_out[3]);

    p_hs_low_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && !$past(pix_stb)) |-> (lane_out == '0 && !clk_lane_out));

endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_stb      (pix_stb),
    .de_in        (de_in),
    .hs_in        (hs_in),
    .vs_in        (vs_in),
    .depth_q      (depth_q),
    .lane_out     (lane_out),
    .clk_lane_out (clk_lane_out)
);

// File: tb/tb_lvds_pixel_serializer.sv
// Sweeps every mode code with zero, all-ones, walking-one and pseudo-random
// pixels, rebuilding each lane's seven slots and comparing to expected words.
module tb_lvds_pixel_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_stb = 1'b0;
    logic [1:0] depth_sel = 2'b00;
    logic       jeida_sel = 1'b0;
    logic [9:0] r_in = '0, g_in = '0, b_in = '0;
    logic       de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic [4:0] lane_out;
    logic       clk_lane_out;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] lfsr = 32'hACE1_1234;

    always #2.5 clk = ~clk;

    lvds_pixel_serializer dut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .depth_sel(depth_sel),
        .jeida_sel(jeida_sel), .r_in(r_in), .g_in(g_in), .b_in(b_in),
        .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
        .lane_out(lane_out), .clk_lane_out(clk_lane_out)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int depth_of(input logic [1:0] d);
        return (d == 2'b10) ? 30 : (d == 2'b01) ? 24 : 18;
    endfunction

    function automatic string mode_tag(input logic [1:0] d, input bit j);
        int w = depth_of(d);
        if (w == 18) return "R4 R1 R11";
        if (w == 24) return j ? "R6 R1 R11" : "R5 R1 R11";
        return j ? "R8 R1 R11" : "R7 R1 R11";
    endfunction

    // Expected seven-slot word of one lane, computed from the requirements.
    function automatic logic [6:0] exp_lane(input int lane, input logic [1:0] d,
            input bit j, input logic [9:0] r, g, b, input bit de, hs, vs);
        logic [6:0] w = '0;
        int dep = depth_of(d);
        int o = (j && dep == 30) ? 4 : (j && dep == 24) ? 2 : 0;
        int e = 0;
        bit act = 1'b1;
        if (lane == 3) begin act = (dep >= 24); e = j ? ((dep == 30) ? 2 : 0) : 6; end
        if (lane == 4) begin act = (dep == 30); e = j ? 0 : 8; end
        for (int s = 0; s < 7; s++) begin
            case (lane)
                0: w[s] = (s == 0) ? g[o] : r[o + 6 - s];
                1: w[s] = (s == 0) ? b[o + 1] : (s == 1) ? b[o] : g[o + 7 - s];
                2: w[s] = (s == 0) ? de : (s == 1) ? vs : (s == 2) ? hs : b[o + 8 - s];
                default: begin
                    case (s)
                        1: w[s] = b[e + 1];
                        2: w[s] = b[e];
                        3: w[s] = g[e + 1];
                        4: w[s] = g[e];
                        5: w[s] = r[e + 1];
                        6: w[s] = r[e];
                        default: w[s] = 1'b0;
                    endcase
                    if (!act) w[s] = 1'b0;
                end
            endcase
        end
        return w;
    endfunction

    // Drive one pixel at a negedge, collect its seven slots, compare.
    task automatic send_pixel(input logic [1:0] d, input bit j,
            input logic [9:0] r, g, b, input bit de, hs, vs);
        logic [6:0] got [5];
        logic [6:0] gclk;
        logic [6:0] ex;
        string tg;
        pix_stb = 1'b1; depth_sel = d; jeida_sel = j;
        r_in = r; g_in = g; b_in = b; de_in = de; hs_in = hs; vs_in = vs;
        @(posedge clk);
        for (int s = 0; s < 7; s++) begin
            if (s > 0) @(posedge clk);
            @(negedge clk);
            if (s == 0) begin
                // Inputs change mid-pixel; the pixel on the lanes must not (R11).
                pix_stb = 1'b0; depth_sel = ~d; jeida_sel = ~j;
                r_in = ~r; g_in = ~g; b_in = ~b; de_in = ~de; hs_in = ~hs; vs_in = ~vs;
            end
            for (int l = 0; l < 5; l++) got[l][s] = lane_out[l];
            gclk[s] = clk_lane_out;
        end
        tg = mode_tag(d, j);
        for (int l = 0; l < 2; l++) begin
            ex = exp_lane(l, d, j, r, g, b, de, hs, vs);
            check(got[l] == ex, $sformatf("%s lane%0d", tg, l), 32'(got[l]), 32'(ex));
        end
        ex = exp_lane(2, d, j, r, g, b, de, hs, vs);
        check(got[2][6:3] == ex[6:3], {tg, " lane2 colour"}, 32'(got[2][6:3]), 32'(ex[6:3]));
        check(got[2][2:0] == {hs, vs, de}, "R3 rebuilt de/vs/hs",
              32'(got[2][2:0]), 32'({hs, vs, de}));
        for (int l = 3; l < 5; l++) begin
            ex = exp_lane(l, d, j, r, g, b, de, hs, vs);
            if (ex == '0 && !((l == 3 && depth_of(d) >= 24) || (l == 4 && depth_of(d) == 30)))
                check(got[l] == '0, $sformatf("R10 unused lane%0d", l), 32'(got[l]), 0);
            else begin
                check(got[l][6:1] == ex[6:1], $sformatf("%s lane%0d", tg, l),
                      32'(got[l]), 32'(ex));
                check(got[l][0] == 1'b0, $sformatf("R9 lane%0d slot0", l), 32'(got[l][0]), 0);
            end
        end
        check(gclk == 7'b1100011, "R2 clock lane", 32'(gclk), 32'h63);
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(lane_out == '0 && !clk_lane_out, "R12 outputs low in reset",
              32'({lane_out, clk_lane_out}), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(lane_out == '0 && !clk_lane_out, "R12 outputs low after reset",
              32'({lane_out, clk_lane_out}), 0);
        for (int m = 0; m < 8; m++) begin
            logic [1:0] d = m[1:0];
            bit j = m[2];
            send_pixel(d, j, '0, '0, '0, 1'b0, 1'b0, 1'b0);
            send_pixel(d, j, '1, '1, '1, 1'b1, 1'b1, 1'b1);
            for (int k = 0; k < 33; k++) begin
                logic [32:0] v = 33'd1 << k;
                send_pixel(d, j, v[32:23], v[22:13], v[12:3], v[2], v[1], v[0]);
            end
            for (int k = 0; k < 20; k++) begin
                lfsr = step(lfsr);
                lfsr = step(lfsr);
                send_pixel(d, j, lfsr[29:20], lfsr[19:10], lfsr[9:0],
                           lfsr[30], lfsr[31], lfsr[15]);
            end
        end
        // No further strobe: lanes drain to zero.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(lane_out == '0 && !clk_lane_out, "R12 idle after last pixel",
              32'({lane_out, clk_lane_out}), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule